// File: doc/BRIEF.md
# Frequency Lock Detector

This block judges whether a PLL feedback clock runs at the same frequency as its reference. Counting is timed by the reference clock. On every reference cycle the block adds the number of feedback edges seen in that cycle to a running total. At the end of each counting window it compares that total with the window length in reference cycles. The feedback edges arrive already synchronized into the reference domain, as a small count per cycle. This keeps the comparison free of any clock-domain crossing.

The block reports lock only after two windows in a row agree exactly. The first window is N cycles long and the second is N+K cycles long. Once locked, it keeps checking in windows of N+K cycles, and it allows an error of one count either way. If a window misses by two or more counts, the live flag drops and qualification starts again. A sticky flag records that lock was reached and holds until reset or an explicit clear. The flags indicate frequency agreement only; phase alignment is not claimed.

Top module: `freq_lock_detect`

## Requirements
- R1: While rstN is low, lockLive and lockSticky are both 0, and both counting windows restart from their beginnings.
- R2: Qualification begins with a window of N reference cycles. If the feedback total for that window is not exactly N, the next window is again an N window, and lockLive stays 0.
- R3: An exact match in the N window is followed by a window of N+K cycles. An exact match there sets lockLive at the edge that closes the window, which is 2N+K cycles after reset is released if every window matches.
- R4: If the N+K qualification window misses by any amount, the block returns to the N window, and lockLive stays 0.
- R5: While locked, windows are N+K cycles long. A total of N+K-1, N+K or N+K+1 keeps lockLive at 1.
- R6: While locked, a window total that differs from N+K by two or more clears lockLive at the edge closing that window. The next window is an N window.
- R7: lockSticky becomes 1 at the same edge at which lockLive rises. It stays 1 through a later loss of lock.
- R8: stickyClr high at a clock edge clears lockSticky at that edge, except when lock is acquired at the same edge, in which case lockSticky is 1.
- R9: The feedback total is the sum of the fbEdges values (0 to 2^EDGE_W-1) over the cycles of the window, so several edges in one cycle count separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fbEdges | input | EDGE_W | Number of feedback edges seen in this reference cycle, already synchronized |
| stickyClr | input | 1 | Synchronous clear of the sticky flag |
| lockLive | output | 1 | Current frequency-lock status |
| lockSticky | output | 1 | Set when lock is acquired, held until cleared |

## Verification
Both flags are registers. They change only at the rising edge that samples the last cycle of a window, or, for lockSticky, at an edge with stickyClr high. A window of L cycles therefore resolves exactly L edges after it opens. The bench drives fbEdges and stickyClr on the falling edge and advances its own window model by one cycle per step. It compares both flags on the next falling edge, which falls between the edge that updated them and the edge that will next update them. This holds the expected value to the precise closing cycle, for example lockLive rising on the 2N+K-th step after reset.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic longWin;   // current window lasts N+K cycles instead of N
    logic tolWide;   // accept a total within one count of the window length
  } lockCtrl_t;

  typedef enum logic [1:0] {
    ST_QUAL_N  = 2'd0,
    ST_QUAL_NK = 2'd1,
    ST_LOCKED  = 2'd2
  } lockState_t;

endpackage

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int N      = 8,
  parameter int K      = 3,
  parameter int EDGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockCtrl_t         ctrl,
  input  logic [EDGE_W-1:0] fbEdges,
  output logic              winEnd,
  output logic              winMatch
);

  localparam int LONG    = N + K;
  localparam int MAX_FB  = LONG * ((1 << EDGE_W) - 1) + 2;
  localparam int FB_W    = $clog2(MAX_FB + 1);
  localparam int CNT_W   = $clog2(LONG + 2);
  localparam logic [FB_W:0]    SHORT_LEN = (FB_W+1)'(N);
  localparam logic [FB_W:0]    LONG_LEN  = (FB_W+1)'(LONG);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(N - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG - 1);
  localparam logic [FB_W:0]    ONE       = (FB_W+1)'(1);

  logic [CNT_W-1:0] refCnt;
  logic [FB_W-1:0]  fbCnt;
  logic [FB_W:0]    fbTotal;
  logic [FB_W:0]    winLen;
  logic             exactHit;
  logic             nearHit;

  always_comb begin
    winLen   = ctrl.longWin ? LONG_LEN : SHORT_LEN;
    fbTotal  = {1'b0, fbCnt} + {{(FB_W+1-EDGE_W){1'b0}}, fbEdges};
    winEnd   = (refCnt == (ctrl.longWin ? LONG_END : SHORT_END));
    exactHit = (fbTotal == winLen);
    nearHit  = ((fbTotal + ONE) >= winLen) && (fbTotal <= (winLen + ONE));
    winMatch = ctrl.tolWide ? nearHit : exactHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else if (winEnd) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else begin
      refCnt <= refCnt + CNT_W'(1);
      fbCnt  <= fbTotal[FB_W-1:0];
    end
  end

endmodule

// File: rtl/lockdet_control.sv
module lockdet_control
  import lockdet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      winEnd,
  input  logic      winMatch,
  input  logic      stickyClr,
  output lockCtrl_t ctrl,
  output logic      lockLive,
  output logic      lockSticky
);

  lockState_t state;
  lockState_t nextState;
  logic       acquire;

  always_comb begin
    nextState = state;
    acquire   = 1'b0;
    if (winEnd) begin
      case (state)
        ST_QUAL_N:  nextState = winMatch ? ST_QUAL_NK : ST_QUAL_N;
        ST_QUAL_NK: begin
          nextState = winMatch ? ST_LOCKED : ST_QUAL_N;
          acquire   = winMatch;
        end
        ST_LOCKED:  nextState = winMatch ? ST_LOCKED : ST_QUAL_N;
        default:    nextState = ST_QUAL_N;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_QUAL_N;
      lockSticky <= 1'b0;
    end else begin
      state <= nextState;
      if (acquire)        lockSticky <= 1'b1;
      else if (stickyClr) lockSticky <= 1'b0;
    end
  end

  assign lockLive     = (state == ST_LOCKED);
  assign ctrl.longWin = (state != ST_QUAL_N);
  assign ctrl.tolWide = (state == ST_LOCKED);

endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
  import lockdet_pkg::*;
#(
  parameter int N      = 8,
  parameter int K      = 3,
  parameter int EDGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EDGE_W-1:0] fbEdges,
  input  logic              stickyClr,
  output logic              lockLive,
  output logic              lockSticky
);

  lockCtrl_t ctrlBus;
  logic      winEnd;
  logic      winMatch;
  logic      winLong;

  assign winLong = ctrlBus.longWin;

  lockdet_datapath #(.N(N), .K(K), .EDGE_W(EDGE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlBus),
    .fbEdges  (fbEdges),
    .winEnd   (winEnd),
    .winMatch (winMatch)
  );

  lockdet_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .winEnd     (winEnd),
    .winMatch   (winMatch),
    .stickyClr  (stickyClr),
    .ctrl       (ctrlBus),
    .lockLive   (lockLive),
    .lockSticky (lockSticky)
  );

endmodule

// File: rtl/freq_lock_detect_chk.sv
module freq_lock_detect_chk (
  input logic clk,
  input logic rstN,
  input logic stickyClr,
  input logic lockLive,
  input logic lockSticky,
  input logic winEnd,
  input logic winLong
);

  // R2
  live_only_at_window_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockLive) |-> $past(winEnd));

  // R3
  acquire_after_long_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockLive) |-> $past(winEnd && winLong));

  // R6
  loss_restarts_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockLive) |-> (!winLong && $past(winEnd)));

  // R7
  sticky_rise_with_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockSticky) |-> $rose(lockLive));

  // R7
  sticky_set_on_acquire_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockLive) |-> lockSticky);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockSticky && !stickyClr) |=> lockSticky);

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyClr |=> (!lockSticky || $rose(lockLive)));

endmodule

bind freq_lock_detect freq_lock_detect_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stickyClr  (stickyClr),
  .lockLive   (lockLive),
  .lockSticky (lockSticky),
  .winEnd     (winEnd),
  .winLong    (winLong)
);

// File: tb/freq_lock_detect_bench.sv
module freq_lock_detect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int K  = 3;
  localparam int EW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [EW-1:0] fbEdges = '0;
  logic          stickyClr = 1'b0;
  logic          lockLive;
  logic          lockSticky;

  int  checks = 0;
  int  errors = 0;
  int  mState = 0;   // 0 = short window, 1 = long qualify, 2 = locked
  int  mCnt = 0;
  int  mFb = 0;
  bit  mLock = 1'b0;
  bit  mSticky = 1'b0;

  freq_lock_detect #(.N(N), .K(K), .EDGE_W(EW)) u_freq_lock_detect (
    .clk        (clk),
    .rstN       (rstN),
    .fbEdges    (fbEdges),
    .stickyClr  (stickyClr),
    .lockLive   (lockLive),
    .lockSticky (lockSticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int winLenOf(int st);
    return (st == 0) ? N : N + K;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic modelAdvance(int e, bit clr);
    int len;
    int diff;
    bit ok;
    bit acq;
    len = winLenOf(mState);
    mFb += e;
    mCnt++;
    acq = 1'b0;
    if (mCnt == len) begin
      diff = mFb - len;
      ok = (mState == 2) ? (diff >= -1 && diff <= 1) : (diff == 0);
      case (mState)
        0: mState = ok ? 1 : 0;
        1: begin mState = ok ? 2 : 0; acq = ok; end
        default: mState = ok ? 2 : 0;
      endcase
      mCnt = 0;
      mFb = 0;
    end
    mLock = (mState == 2);
    if (acq) mSticky = 1'b1;
    else if (clr) mSticky = 1'b0;
  endtask

  task automatic step(int e, bit clr, string tag);
    fbEdges = EW'(e);
    stickyClr = clr;
    modelAdvance(e, clr);
    @(posedge clk);
    @(negedge clk);
    check(tag, "lockLive", lockLive, mLock);
    check(tag, "lockSticky", lockSticky, mSticky);
  endtask

  task automatic runWindow(int len, int extra, string tag);
    for (int i = 0; i < len; i++) step((i == len - 1) ? 1 + extra : 1, 1'b0, tag);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int r;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: flags clear in reset
    check("R1", "lockLive in reset", lockLive, 1'b0);
    check("R1", "lockSticky in reset", lockSticky, 1'b0);
    rstN = 1'b1;

    // R2/R3: clean qualification, lock after 2N+K cycles
    runWindow(N, 0, "R2");
    check("R2", "no lock after short window", lockLive, 1'b0);
    runWindow(N + K - 1, 0, "R3");
    check("R3", "no lock one cycle early", lockLive, 1'b0);
    step(1, 1'b0, "R3");
    check("R3", "lock at 2N+K", lockLive, 1'b1);
    check("R7", "sticky with lock", lockSticky, 1'b1);

    // R5: off by one either way keeps lock
    runWindow(N + K, 1, "R5");
    runWindow(N + K, -1, "R5");
    check("R5", "lock kept within one", lockLive, 1'b1);

    // R9: multi-edge cycles, 2/0 pattern totals N+K+1
    for (int i = 0; i < N + K; i++) step((i % 2 == 0) ? 2 : 0, 1'b0, "R9");
    check("R9", "summed edges keep lock", lockLive, 1'b1);

    // R6/R7: off by two loses lock, sticky holds
    runWindow(N + K, 2, "R6");
    check("R6", "lock lost", lockLive, 1'b0);
    check("R7", "sticky survives loss", lockSticky, 1'b1);

    // R8: explicit clear
    step(1, 1'b1, "R8");
    check("R8", "sticky cleared", lockSticky, 1'b0);
    runWindow(N - 1, 0, "R2");

    // R4: long window mismatch returns to short window
    runWindow(N + K, 1, "R4");
    check("R4", "no lock after long miss", lockLive, 1'b0);

    // R2: short window mismatch repeats short window
    runWindow(N, -1, "R2");
    check("R2", "no lock after short miss", lockLive, 1'b0);
    runWindow(N, 0, "R2");
    runWindow(N + K - 1, 0, "R3");
    // R8: acquisition wins over a clear in the same cycle
    step(1, 1'b1, "R8");
    check("R8", "acquire beats clear", lockSticky, 1'b1);
    check("R3", "relock", lockLive, 1'b1);

    // random stretch
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 16);
      step((r <= 12) ? 1 : (r == 13) ? 0 : (r == 14) ? 2 : 3,
           ($urandom % 64) == 0, "R5");
    end

    finishRun();
  end

endmodule